// File: doc/BRIEF.md
# Dual Noise Source Health Monitor

This block watches two single-bit entropy streams for faults. The two streams share one sample strobe. It looks for two kinds of fault on each stream. The first is a stuck stream, where one value repeats for too many samples. The second is an oscillating stream, where the same alternating bit pair repeats for too many pairs. There are two threshold tiers. The looser tier applies when only one stream misbehaves. The stricter tier applies when both streams misbehave at the same time.

The result appears on three outputs:
- A live error flag, which follows the current condition.
- A sticky error flag, which holds until software clears it by writing a 0 through a write strobe.
- An interrupt line, which is the sticky flag gated by an enable.

The sample strobe advances all counting. The block makes no further use of the stream values.

Top module: `noise_health_mon`

## Requirements
- R1: A stream whose run of identical samples (counting the current sample) exceeds CONST_SGL (default 64) raises `err_live`. A run of exactly 64 does not raise it. Sample 65 does.
- R2: Samples of each stream are grouped into non-overlapping pairs, starting from the first sample after reset. The first bit of a pair is the older bit. If more than ALT_SGL (default 32) consecutive pairs are the same alternating pair (01 or 10), `err_live` is raised.
- R3: When both streams at once have a constant run longer than CONST_DUAL (default 32), `err_live` is raised. The two streams do not need to hold the same value. A single stream with a run of 33 to 64 raises nothing.
- R4: When both streams at once have more than ALT_DUAL (default 16) repeated identical alternating pairs, `err_live` is raised. A single stream with 17 to 32 such pairs raises nothing.
- R5: The alternation count falls to zero on a 00 or 11 pair. It restarts at one when an alternating pair differs from the previous pair. A pattern such as 0110 repeating therefore never raises a fault.
- R6: `err_live` is registered. It reflects the sample taken at clock edge E from edge E+1 onward. It returns to 0 once no fault condition holds, for example when a stuck stream changes value.
- R7: `err_sticky` rises at the same edge as `err_live`. It is cleared only by `clr_wr`=1 with `clr_data`=0, and only when no fault is present at that edge (a fault takes priority). `clr_wr` with `clr_data`=1 has no effect.
- R8: `irq` equals `err_sticky` AND the value `irq_en` held at the previous edge. It is updated at the same edge as `err_sticky`.
- R9: Only cycles with `smp_vld`=1 advance the counters. Bit values present while `smp_vld`=0 have no effect.
- R10: Counters saturate one above the highest threshold. A stream stuck for any number of samples keeps `err_live` at 1.
- R11: While `rst`=1, the next edge clears all counters, `err_live`, `err_sticky` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe for both streams |
| smp_bit | input | 2 | One bit per stream; bit 0 is stream 0, bit 1 is stream 1 |
| irq_en | input | 1 | Interrupt enable |
| clr_wr | input | 1 | Write strobe to the sticky flag |
| clr_data | input | 1 | Value written; 0 clears, 1 is ignored |
| err_live | output | 1 | Fault currently present |
| err_sticky | output | 1 | Fault seen since the last clear |
| irq | output | 1 | Sticky flag gated by enable |

## Verification
The bench drives each threshold to its exact boundary and one sample past it, in both tiers and for both fault kinds:
- A design with an off-by-one compare would fault one sample early or late.
- A design that mixed up the tiers would fault on a single stream at the dual threshold.
- A 0110 repeating pattern catches a pair counter that does not restart on a changed pair.
- Overlapping pairing is also caught by a phase-sensitive alternation count.
- A 300-sample stuck stream exposes a counter that wraps instead of saturating.

Idle cycles with toggling bits check that the strobe gates the counters. A clear issued during an active fault checks that a fault takes priority over a software clear.

// File: rtl/nhm_pkg.sv
package nhm_pkg;
  localparam int NSRC = 2;

  // Per-stream threshold comparisons, registered in the tracker
  typedef struct packed {
    logic run_sgl;   // constant run above single-stream limit
    logic run_dual;  // constant run above dual-stream limit
    logic alt_sgl;   // alternation above single-stream limit
    logic alt_dual;  // alternation above dual-stream limit
  } trk_flags_t;
endpackage

// File: rtl/nhm_run_tracker.sv
module nhm_run_tracker #(
  parameter int CONST_SGL  = 64,
  parameter int CONST_DUAL = 32,
  parameter int ALT_SGL    = 32,
  parameter int ALT_DUAL   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vld,
  input  logic                bit_in,
  output nhm_pkg::trk_flags_t flags
);
  localparam int CW = $clog2(CONST_SGL + 2);
  localparam int AW = $clog2(ALT_SGL + 2);
  localparam logic [CW-1:0] RUN_MAX = CW'(CONST_SGL + 1);
  localparam logic [AW-1:0] ALT_MAX = AW'(ALT_SGL + 1);

  logic          last_q;
  logic [CW-1:0] run_q, run_d;
  logic          phase_q;   // 1: holding first bit of a pair
  logic          half_q;    // first bit of the current pair
  logic          pfirst_q;  // first bit of the last alternating pair
  logic [AW-1:0] alt_q, alt_d;

  always_comb begin
    if (run_q != '0 && bit_in == last_q)
      run_d = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
    else
      run_d = CW'(1);
  end

  always_comb begin
    alt_d = alt_q;
    if (phase_q) begin
      if (half_q == bit_in)
        alt_d = '0;
      else if (alt_q != '0 && pfirst_q == half_q)
        alt_d = (alt_q == ALT_MAX) ? alt_q : alt_q + 1'b1;
      else
        alt_d = AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q   <= 1'b0;
      run_q    <= '0;
      phase_q  <= 1'b0;
      half_q   <= 1'b0;
      pfirst_q <= 1'b0;
      alt_q    <= '0;
      flags    <= '0;
    end else if (vld) begin
      last_q  <= bit_in;
      run_q   <= run_d;
      phase_q <= ~phase_q;
      if (!phase_q) half_q <= bit_in;
      else          pfirst_q <= half_q;
      alt_q          <= alt_d;
      flags.run_sgl  <= run_d > CW'(CONST_SGL);
      flags.run_dual <= run_d > CW'(CONST_DUAL);
      flags.alt_sgl  <= alt_d > AW'(ALT_SGL);
      flags.alt_dual <= alt_d > AW'(ALT_DUAL);
    end
  end
endmodule

// File: rtl/nhm_flag_ctrl.sv
module nhm_flag_ctrl (
  input  logic                                  clk,
  input  logic                                  rst,
  input  nhm_pkg::trk_flags_t [nhm_pkg::NSRC-1:0] flags,
  input  logic                                  irq_en,
  input  logic                                  clr_wr,
  input  logic                                  clr_data,
  output logic                                  err_live,
  output logic                                  err_sticky,
  output logic                                  irq
);
  logic [nhm_pkg::NSRC-1:0] run_s, run_d2, alt_s, alt_d2;
  logic fault, sticky_nxt;

  for (genvar g = 0; g < nhm_pkg::NSRC; g++) begin : g_unpack
    assign run_s[g]  = flags[g].run_sgl;
    assign run_d2[g] = flags[g].run_dual;
    assign alt_s[g]  = flags[g].alt_sgl;
    assign alt_d2[g] = flags[g].alt_dual;
  end

  assign fault      = (|run_s) | (|alt_s) | (&run_d2) | (&alt_d2);
  assign sticky_nxt = fault | (err_sticky & ~(clr_wr & ~clr_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      err_live   <= 1'b0;
      err_sticky <= 1'b0;
      irq        <= 1'b0;
    end else begin
      err_live   <= fault;
      err_sticky <= sticky_nxt;
      irq        <= sticky_nxt & irq_en;
    end
  end
endmodule

// File: rtl/noise_health_mon.sv
module noise_health_mon #(
  parameter int CONST_SGL  = 64,
  parameter int CONST_DUAL = 32,
  parameter int ALT_SGL    = 32,
  parameter int ALT_DUAL   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_vld,
  input  logic [nhm_pkg::NSRC-1:0] smp_bit,
  input  logic                     irq_en,
  input  logic                     clr_wr,
  input  logic                     clr_data,
  output logic                     err_live,
  output logic                     err_sticky,
  output logic                     irq
);
  nhm_pkg::trk_flags_t [nhm_pkg::NSRC-1:0] trk_flags;

  for (genvar s = 0; s < nhm_pkg::NSRC; s++) begin : g_src
    nhm_run_tracker #(
      .CONST_SGL (CONST_SGL),
      .CONST_DUAL(CONST_DUAL),
      .ALT_SGL   (ALT_SGL),
      .ALT_DUAL  (ALT_DUAL)
    ) u_trk (
      .clk   (clk),
      .rst   (rst),
      .vld   (smp_vld),
      .bit_in(smp_bit[s]),
      .flags (trk_flags[s])
    );
  end

  nhm_flag_ctrl u_flags (
    .clk       (clk),
    .rst       (rst),
    .flags     (trk_flags),
    .irq_en    (irq_en),
    .clr_wr    (clr_wr),
    .clr_data  (clr_data),
    .err_live  (err_live),
    .err_sticky(err_sticky),
    .irq       (irq)
  );
endmodule

// File: rtl/nhm_checker.sv
module nhm_checker (
  input logic clk,
  input logic rst,
  input logic smp_vld,
  input logic irq_en,
  input logic clr_wr,
  input logic clr_data,
  input logic err_live,
  input logic err_sticky,
  input logic irq
);
  // R7: sticky is never below live
  a_r7_sticky_covers_live: assert property (@(posedge clk) disable iff (rst)
    err_live |-> err_sticky);

  // R7: sticky only rises together with live
  a_r7_rise_with_live: assert property (@(posedge clk) disable iff (rst)
    $rose(err_sticky) |-> err_live);

  // R7: without a zero write the sticky flag holds
  a_r7_hold_unless_zero: assert property (@(posedge clk) disable iff (rst)
    (err_sticky && !(clr_wr && !clr_data)) |=> err_sticky);

  // R8: interrupt is sticky gated by the enable of the previous edge
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq == ($past(irq_en) && err_sticky));

  // R9: two idle strobes leave the live flag unchanged
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!smp_vld && $past(!smp_vld)) |=> $stable(err_live));

  // R11: reset clears all outputs
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!err_live && !err_sticky && !irq));
endmodule

bind noise_health_mon nhm_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_vld   (smp_vld),
  .irq_en    (irq_en),
  .clr_wr    (clr_wr),
  .clr_data  (clr_data),
  .err_live  (err_live),
  .err_sticky(err_sticky),
  .irq       (irq)
);

// File: tb/sim_noise_health_mon.sv
`timescale 1ns/1ps
module sim_noise_health_mon;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_vld = 1'b0;
  logic [1:0] smp_bit = 2'b00;
  logic       irq_en = 1'b0;
  logic       clr_wr = 1'b0;
  logic       clr_data = 1'b0;
  logic       err_live, err_sticky, irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  noise_health_mon u0 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_bit(smp_bit),
    .irq_en(irq_en), .clr_wr(clr_wr), .clr_data(clr_data),
    .err_live(err_live), .err_sticky(err_sticky), .irq(irq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; smp_vld = 1'b0; clr_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic b0, input logic b1);
    @(negedge clk); smp_vld = 1'b1; smp_bit = {b1, b0};
    @(negedge clk); smp_vld = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic d);
    @(negedge clk); clr_wr = 1'b1; clr_data = d;
    @(negedge clk); clr_wr = 1'b0;
  endtask

  // filler stream 0011...: runs of 2, pairs 00/11 only
  function automatic logic fill(input int i);
    return logic'((i >> 1) & 1);
  endfunction

  task automatic t_reset();
    do_reset(); settle();
    chk("R11 reset live", err_live, 1'b0);
    chk("R11 reset sticky", err_sticky, 1'b0);
    chk("R11 reset irq", irq, 1'b0);
  endtask

  task automatic t_single_const();
    do_reset();
    for (int i = 0; i < 64; i++) push(1'b0, fill(i));
    settle(); chk("R1 run of 64", err_live, 1'b0);
    push(1'b0, fill(64)); settle();
    chk("R1 run of 65", err_live, 1'b1);
    chk("R7 sticky set", err_sticky, 1'b1);
    chk("R8 irq disabled", irq, 1'b0);
    push(1'b1, fill(65)); settle();
    chk("R6 live drops", err_live, 1'b0);
    chk("R7 sticky holds", err_sticky, 1'b1);
    wr(1'b1); settle();
    chk("R7 write one ignored", err_sticky, 1'b1);
    @(negedge clk); irq_en = 1'b1; settle();
    chk("R8 irq enabled", irq, 1'b1);
    wr(1'b0); settle();
    chk("R7 write zero clears", err_sticky, 1'b0);
    chk("R8 irq follows clear", irq, 1'b0);
    @(negedge clk); irq_en = 1'b0;
  endtask

  task automatic t_dual_const();
    do_reset();
    for (int i = 0; i < 40; i++) push(1'b0, fill(i));
    settle(); chk("R3 single run 40 no fault", err_live, 1'b0);
    do_reset();
    for (int i = 0; i < 32; i++) push(1'b0, 1'b1);
    settle(); chk("R3 dual run 32", err_live, 1'b0);
    push(1'b0, 1'b1); settle();
    chk("R3 dual run 33", err_live, 1'b1);
  endtask

  task automatic t_single_alt();
    do_reset();
    for (int i = 0; i < 34; i++) push(logic'(i & 1), fill(i));
    settle(); chk("R4 single alt 17 pairs no fault", err_live, 1'b0);
    for (int i = 34; i < 64; i++) push(logic'(i & 1), fill(i));
    settle(); chk("R2 alt 32 pairs", err_live, 1'b0);
    push(1'b0, fill(64)); settle();
    chk("R2 half pair no change", err_live, 1'b0);
    push(1'b1, fill(65)); settle();
    chk("R2 alt 33 pairs", err_live, 1'b1);
  endtask

  task automatic t_dual_alt();
    do_reset();
    for (int i = 0; i < 32; i++) push(logic'(i & 1), logic'(~i & 1));
    settle(); chk("R4 dual alt 16 pairs", err_live, 1'b0);
    push(1'b0, 1'b1); push(1'b1, 1'b0); settle();
    chk("R4 dual alt 17 pairs", err_live, 1'b1);
  endtask

  task automatic t_mixed_pairs();
    do_reset();
    for (int i = 0; i < 200; i++) begin
      logic b;
      b = logic'(((i >> 1) ^ i) & 1);
      push(b, b);
    end
    settle(); chk("R5 0110 pattern no fault", err_live, 1'b0);
    chk("R5 0110 pattern sticky", err_sticky, 1'b0);
  endtask

  task automatic t_vld_gate();
    do_reset();
    for (int i = 0; i < 20; i++) push(1'b0, 1'b1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); smp_vld = 1'b0; smp_bit = logic'(i & 1) ? 2'b01 : 2'b10;
    end
    for (int i = 0; i < 12; i++) push(1'b0, 1'b1);
    settle(); chk("R9 idle bits ignored, run 32", err_live, 1'b0);
    push(1'b0, 1'b1); settle();
    chk("R9 run 33 across idle", err_live, 1'b1);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 200; i++) push(1'b1, fill(i));
    settle(); chk("R10 stuck 200", err_live, 1'b1);
    for (int i = 200; i < 300; i++) push(1'b1, fill(i));
    settle(); chk("R10 stuck 300", err_live, 1'b1);
    wr(1'b0); settle();
    chk("R7 fault beats clear", err_sticky, 1'b1);
    @(negedge clk); irq_en = 1'b1; settle();
    chk("R8 irq set", irq, 1'b1);
    do_reset(); settle();
    chk("R11 reset clears live", err_live, 1'b0);
    chk("R11 reset clears sticky", err_sticky, 1'b0);
    chk("R11 reset clears irq", irq, 1'b0);
    @(negedge clk); irq_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_single_const();
    t_dual_const();
    t_single_alt();
    t_dual_alt();
    t_mixed_pairs();
    t_vld_gate();
    t_saturate();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule